// File: doc/BRIEF.md
# Iterative Integer-to-Float Normalizer

This block turns an unsigned 64-bit integer into a floating-point style pair: a left-justified mantissa whose most significant bit is the hidden one, and an exponent. It does not use a full-width priority encoder. The leading one is found over several cycles in two phases. In the coarse phase, the working copy moves up a whole byte per cycle for as long as its top byte is zero. In the fine phase, it moves up one bit per cycle until its top bit is set. A 64-bit conversion therefore spends at most 14 cycles shifting, instead of up to 63.

A conversion begins with a one-cycle `start` pulse while the block is idle. The result appears on the mantissa, exponent and zero outputs, and a one-cycle `done` strobe marks it. The result stays on the outputs until the next accepted start. The exponent is 63 minus the number of bit positions shifted, plus a bias taken from the `exp_bias` input. An all-zero input is detected during the byte scan and is reported with the zero flag.

The controller has four states:
- `ST_IDLE` waits. IDLE→SCAN happens on `start` and loads the input.
- `ST_SCAN` performs byte steps.
  - SCAN→SCAN: the top byte is zero and this is not the last byte.
  - SCAN→FINE: the top byte is nonzero.
  - SCAN→DONE: the top byte is zero at the last byte, so the input is zero.
- `ST_FINE` performs single-bit steps.
  - FINE→FINE: the top bit is clear.
  - FINE→DONE: the top bit is set.
- `ST_DONE` lasts one cycle. DONE→IDLE is unconditional.

Top module: `int2float_norm`

## Requirements
- R1: After reset, `done` is 0, `zero` is 0 and `mant` is 0.
- R2: For a nonzero input, `mant` at `done` equals the input shifted left by its leading-zero count L, so `mant[63]` is 1.
- R3: For a nonzero input, `exp_out` at `done` equals `exp_bias + 63 - L`, taken modulo 2^11.
- R4: While the top byte is zero, the coarse phase advances 8 positions per cycle. With B = floor(L/8) byte steps and b = L mod 8 bit steps, `done` rises on the clock edge that is B+b+2 edges after the edge that samples `start`. For an input of 1 this is 16.
- R5: For an all-zero input, `done` rises 8 edges after the start edge. At that point `zero` is 1, `mant` is 0 and `exp_out` is 0.
- R6: `done` is high for exactly one cycle. `mant`, `exp_out` and `zero` hold their values after `done` until the next accepted start.
- R7: A `start` pulse while a conversion is in progress is ignored. The running result and its timing are unchanged.
- R8: For a nonzero input, `zero` is 0 at `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion (honoured in idle only) |
| din | input | 64 | Unsigned integer to convert |
| exp_bias | input | 11 | Bias added to the exponent |
| mant | output | 64 | Left-justified mantissa, hidden one at bit 63 |
| exp_out | output | 11 | Biased exponent |
| zero | output | 1 | Input was zero |
| done | output | 1 | One-cycle completion strobe |

## Verification
The in-RTL assertions check several properties on every cycle:
- `done` is a single-cycle pulse.
- A nonzero result has bit 63 set, and a zero result has a clear mantissa.
- The shift count stays byte-aligned through the coarse phase.
- A running conversion never falls back to idle.
- The working register holds while the block is idle.

Only the bench scenarios show the following:
- the exact mantissa and exponent values;
- the latency that follows from the split of the leading-zero count into byte and bit steps;
- that a start pulse arriving mid-conversion leaves both result and timing untouched.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FINE = 2'd2,
        ST_DONE = 2'd3
    } nrm_state_e;
endpackage

// File: rtl/nrm_fsm.sv
module nrm_fsm
    import nrm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       top_zero,
    input  logic       last_byte,
    input  logic       msb_set,
    output nrm_state_e state
);
    nrm_state_e state_q;
    nrm_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SCAN;
            ST_SCAN: begin
                if (!top_zero)     state_d = ST_FINE;
                else if (last_byte) state_d = ST_DONE;
            end
            ST_FINE: if (msb_set) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

    // R7: a running conversion never returns straight to idle
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN || state_q == ST_FINE) |=> (state_q != ST_IDLE));

    // R6: the completion state lasts one cycle
    a_r6_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/nrm_datapath.sv
module nrm_datapath
    import nrm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int STEP_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  nrm_state_e        state,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] work,
    output logic [CNT_W-1:0]  shift_cnt,
    output logic              is_zero,
    output logic              top_zero,
    output logic              last_byte,
    output logic              msb_set
);
    localparam int LAST_CNT = DATA_W - STEP_W;

    logic [DATA_W-1:0] work_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              zero_q;

    assign top_zero  = (work_q[DATA_W-1 -: STEP_W] == '0);
    assign last_byte = (cnt_q == CNT_W'(LAST_CNT));
    assign msb_set   = work_q[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
            cnt_q  <= '0;
            zero_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    work_q <= din;
                    cnt_q  <= '0;
                    zero_q <= 1'b0;
                end
                ST_SCAN: if (top_zero) begin
                    if (last_byte) begin
                        zero_q <= 1'b1;
                    end else begin
                        work_q <= work_q << STEP_W;
                        cnt_q  <= cnt_q + CNT_W'(STEP_W);
                    end
                end
                ST_FINE: if (!msb_set) begin
                    work_q <= work_q << 1;
                    cnt_q  <= cnt_q + CNT_W'(1);
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign work      = work_q;
    assign shift_cnt = cnt_q;
    assign is_zero   = zero_q;

    // R4: the coarse phase only ever moves in whole bytes
    a_r4_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> (cnt_q % CNT_W'(STEP_W) == '0));

    // R6: the working register holds while idle without a start
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(work_q));
endmodule

// File: rtl/nrm_expo.sv
module nrm_expo #(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [CNT_W-1:0] shift_cnt,
    input  logic             is_zero,
    input  logic [EXP_W-1:0] bias,
    output logic [EXP_W-1:0] exponent
);
    logic [EXP_W-1:0] cnt_ext;
    assign cnt_ext = EXP_W'(shift_cnt);

    always_comb begin
        if (is_zero) exponent = '0;
        else         exponent = bias + EXP_W'(DATA_W - 1) - cnt_ext;
    end
endmodule

// File: rtl/int2float_norm.sv
module int2float_norm
    import nrm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int STEP_W = 8,
    parameter int EXP_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  logic [EXP_W-1:0]  exp_bias,
    output logic [DATA_W-1:0] mant,
    output logic [EXP_W-1:0]  exp_out,
    output logic              zero,
    output logic              done
);
    localparam int CNT_W = $clog2(DATA_W);

    nrm_state_e        state;
    logic [DATA_W-1:0] work;
    logic [CNT_W-1:0]  shift_cnt;
    logic              is_zero;
    logic              top_zero;
    logic              last_byte;
    logic              msb_set;
    logic [EXP_W-1:0]  exponent;

    nrm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .top_zero  (top_zero),
        .last_byte (last_byte),
        .msb_set   (msb_set),
        .state     (state)
    );

    nrm_datapath #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .start     (start),
        .din       (din),
        .work      (work),
        .shift_cnt (shift_cnt),
        .is_zero   (is_zero),
        .top_zero  (top_zero),
        .last_byte (last_byte),
        .msb_set   (msb_set)
    );

    nrm_expo #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_exp (
        .shift_cnt (shift_cnt),
        .is_zero   (is_zero),
        .bias      (exp_bias),
        .exponent  (exponent)
    );

    always_comb begin
        done    = (state == ST_DONE);
        mant    = work;
        exp_out = exponent;
        zero    = is_zero;
    end

    // R6: done is a single-cycle pulse
    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: a nonzero result carries the hidden one at the top
    a_r2_hidden_one: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !zero) |-> mant[DATA_W-1]);

    // R5: a zero result has an empty mantissa and exponent
    a_r5_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero) |-> (mant == '0 && exp_out == '0));
endmodule

// File: tb/int2float_norm_tb.sv
module int2float_norm_tb;
    localparam int NV = 10;
    localparam logic [63:0] VEC [NV] = '{
        64'h8000_0000_0000_0000,
        64'h0000_0000_0000_0001,
        64'h0000_0000_0000_00FF,
        64'h0000_0000_0000_0100,
        64'h00FF_0000_0000_0000,
        64'h0000_0001_0000_0000,
        64'h7FFF_FFFF_FFFF_FFFF,
        64'h0080_0000_0000_0000,
        64'h0000_0000_0000_0003,
        64'h0123_4567_89AB_CDEF
    };
    localparam logic [10:0] BIAS [NV] = '{
        11'd1023, 11'd0, 11'd1023, 11'd5, 11'd2000,
        11'd1023, 11'd0, 11'd100, 11'd2047, 11'd1023
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] din = '0;
    logic [10:0] exp_bias = '0;
    logic [63:0] mant;
    logic [10:0] exp_out;
    logic        zero;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    int2float_norm u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .din(din),
        .exp_bias(exp_bias), .mant(mant), .exp_out(exp_out),
        .zero(zero), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lzc(input logic [63:0] v);
        int n = 64;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) begin
                n = 63 - i;
                break;
            end
        end
        return n;
    endfunction

    // start at a negedge, return edges from the start edge to done
    task automatic convert(input logic [63:0] v, input logic [10:0] b,
                           input bool_intr, input logic [63:0] v_intr,
                           output int lat);
        int k = 0;
        din = v; exp_bias = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && k < 40) begin
            @(negedge clk);
            k++;
            if (bool_intr && k == 3) begin
                start = 1'b1; din = v_intr;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        lat = k;
        if (k >= 40) begin
            fails++;
            $display("FAIL watchdog: done never rose");
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        int lat;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done", 64'(done), 64'd0);
        check("R1 zero", 64'(zero), 64'd0);
        check("R1 mant", mant, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            int l;
            int bb;
            int bt;
            l  = lzc(VEC[i]);
            bb = l / 8;
            bt = l % 8;
            convert(VEC[i], BIAS[i], 1'b0, '0, lat);
            check("R2 mant", mant, VEC[i] << l);
            check("R3 exp", 64'(exp_out), 64'(11'(BIAS[i] + 11'd63 - 11'(l))));
            check("R8 zero", 64'(zero), 64'd0);
            check("R4 latency", 64'(lat), 64'(bb + bt + 2));
            held = mant;
            @(negedge clk);
            check("R6 pulse", 64'(done), 64'd0);
            repeat (2) @(negedge clk);
            check("R6 hold", mant, held);
        end

        // R5: zero input
        convert(64'd0, 11'd1023, 1'b0, '0, lat);
        check("R5 zero", 64'(zero), 64'd1);
        check("R5 mant", mant, 64'd0);
        check("R5 exp", 64'(exp_out), 64'd0);
        check("R5 latency", 64'(lat), 64'd8);
        @(negedge clk);

        // R7: start mid-conversion is ignored
        convert(64'd1, 11'd1023, 1'b1, 64'h8000_0000_0000_0000, lat);
        check("R7 mant", mant, 64'h8000_0000_0000_0000);
        check("R7 exp", 64'(exp_out), 64'(11'd1023));
        check("R7 latency", 64'(lat), 64'd16);
        @(negedge clk);

        // R8: a nonzero result after a zero one clears the flag
        convert(64'h0000_0000_0000_0010, 11'd0, 1'b0, '0, lat);
        check("R8 zero clears", 64'(zero), 64'd0);
        check("R3 exp small", 64'(exp_out), 64'd4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule